// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits next to a processor's control registers. It decides, once per clock, whether the core enters a handler. A pending synchronous exception and a pending external interrupt can arrive in the same cycle. The block arbitrates between them and applies the blocking rules held in the status register. It then produces everything the core must commit on entry: the saved status, saved program counter and saved stack pointer, the event code, the new status word and the handler address.

The results are registered. On the clock edge after the request is sampled, the block raises `take_event` for one cycle together with the updated register values. That pulse also tells the core to clear its sleep flag and its delay-slot flags. `expevt_ld` or `intevt_ld` shows which event register was written. When nothing is taken, every output register keeps its value.

The status-register bit positions are fixed, because the rest of the core decodes them. Bit 28 blocks events, bit 29 selects the register bank, bit 30 is privileged mode, bit 15 disables the FPU and bits 7:4 hold the interrupt mask.

Top module: `trap_entry_seq`

## Requirements
- R1: When `exc_valid` and `irq_valid` are both high, the exception is taken. `expevt_ld` pulses and `intevt_ld` stays low.
- R2: When SR bit 28 is set, a pending exception with a code other than 0x1E0 is taken as code 0x000 (reset class). Code 0x1E0 keeps its own code and handling.
- R3: When SR bit 28 is set and `in_sleep` is low, a pending interrupt is ignored. No strobe is raised and all outputs hold. When `in_sleep` is high, the interrupt is evaluated normally.
- R4: An interrupt is taken only if `irq_level` is strictly greater than SR bits 7:4. Otherwise nothing is taken.
- R5: On any taken event, `ssr_q` equals the sampled SR and `sgr_q` equals the sampled R15. `sr_q` is the sampled SR with bits 28, 29 and 30 set.
- R6: When `in_delay_slot` is high, `spc_q` is PC minus 2. Otherwise it is PC, apart from the adjustment in R8.
- R7: Exception codes 0x000, 0x020 and 0x140 clear SR bit 15, set SR bits 7:4 to 0xF and load PC 0xA0000000.
- R8: Exception codes 0x040 and 0x060 load VBR+0x400. All other exception codes load VBR+0x100. Code 0x160 adds 2 to the saved PC, on top of any delay-slot rewind.
- R9: An exception loads its effective code into `expevt_q`. An accepted interrupt loads `irq_vector` into `intevt_q` and sets PC to VBR+0x600. An interrupt leaves SR bits 15 and 7:4 unchanged.
- R10: Outputs change on the edge after the request is sampled. `take_event` is high for exactly that cycle. With no event taken, `take_event`, `expevt_ld` and `intevt_ld` are low and every data output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_in | input | 32 | Current status register |
| pc_in | input | 32 | Current program counter |
| r15_in | input | 32 | Current stack pointer register |
| vbr_in | input | 32 | Vector base register |
| in_delay_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| in_sleep | input | 1 | Core is in sleep state |
| exc_valid | input | 1 | An exception is pending |
| exc_code | input | 12 | Code of the pending exception |
| irq_valid | input | 1 | An interrupt is pending |
| irq_vector | input | 12 | Vector of the highest pending interrupt |
| irq_level | input | 4 | Priority level of that interrupt |
| take_event | output | 1 | Entry committed this cycle; clear sleep and delay-slot flags |
| expevt_ld | output | 1 | Exception event register written |
| intevt_ld | output | 1 | Interrupt event register written |
| ssr_q | output | 32 | Saved status register |
| spc_q | output | 32 | Saved program counter |
| sgr_q | output | 32 | Saved stack pointer |
| sr_q | output | 32 | New status register |
| pc_q | output | 32 | Handler address |
| expevt_q | output | 12 | Exception event code |
| intevt_q | output | 12 | Interrupt event vector |

## Verification
The bench builds the block with its default parameters: 32-bit registers, 12-bit event codes and a 4-bit interrupt mask. With these values, every mask comparison from level 0 to 15 can be reached, and so can the full set of reset-class, miss-class and trap codes. The fixed reset address 0xA0000000 is checked as a real constant. Random SR words set the block bit, the sleep flag and the delay-slot flag independently, so their combinations with every event class are covered. Directed cases pin the strict level comparison at its edge and the combined delay-slot and trap adjustment.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_EXC  = 2'd1,
    EV_IRQ  = 2'd2
  } ev_kind_e;

  // Status-word bit positions decoded by the rest of the core
  localparam int SR_BLOCK_BIT = 28;
  localparam int SR_BANK_BIT  = 29;
  localparam int SR_PRIV_BIT  = 30;
  localparam int SR_FPUOFF_BIT = 15;
  localparam int SR_MASK_LSB  = 4;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_entry_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int LVL_W  = 4,
  parameter logic [CODE_W-1:0] UNBLOCKABLE_CODE = 12'h1E0,
  parameter logic [CODE_W-1:0] RESET_CODE       = '0
) (
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_valid,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [LVL_W-1:0]  sr_mask,
  input  logic              sr_block,
  input  logic              sleeping,
  output ev_kind_e          kind,
  output logic [CODE_W-1:0] eff_code
);

  logic irq_unblocked;
  logic irq_above_mask;

  always_comb begin
    irq_unblocked  = !sr_block || sleeping;
    irq_above_mask = irq_level > sr_mask;

    if (sr_block && (exc_code != UNBLOCKABLE_CODE)) begin
      eff_code = RESET_CODE;
    end else begin
      eff_code = exc_code;
    end

    if (exc_valid) begin
      kind = EV_EXC;
    end else if (irq_valid && irq_unblocked && irq_above_mask) begin
      kind = EV_IRQ;
    end else begin
      kind = EV_NONE;
    end
  end

endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12,
  parameter int LVL_W  = 4,
  parameter logic [XLEN-1:0]   RESET_PC   = 32'hA000_0000,
  parameter logic [XLEN-1:0]   OFS_GEN    = 32'h0000_0100,
  parameter logic [XLEN-1:0]   OFS_MISS   = 32'h0000_0400,
  parameter logic [XLEN-1:0]   OFS_IRQ    = 32'h0000_0600,
  parameter logic [CODE_W-1:0] TRAP_CODE  = 12'h160,
  parameter int                NUM_RST    = 3,
  parameter logic [NUM_RST*CODE_W-1:0] RST_CODES  = {12'h140, 12'h020, 12'h000},
  parameter int                NUM_MISS   = 2,
  parameter logic [NUM_MISS*CODE_W-1:0] MISS_CODES = {12'h060, 12'h040}
) (
  input  ev_kind_e          kind,
  input  logic [CODE_W-1:0] eff_code,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic              in_delay_slot,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   saved_pc
);

  localparam logic [XLEN-1:0] INSN_STEP = XLEN'(2);

  logic [NUM_RST-1:0]  rst_hit;
  logic [NUM_MISS-1:0] miss_hit;

  for (genvar gi = 0; gi < NUM_RST; gi++) begin : g_rst
    assign rst_hit[gi] = (eff_code == RST_CODES[gi*CODE_W +: CODE_W]);
  end

  for (genvar gj = 0; gj < NUM_MISS; gj++) begin : g_miss
    assign miss_hit[gj] = (eff_code == MISS_CODES[gj*CODE_W +: CODE_W]);
  end

  logic is_exc;
  logic is_rst_class;
  logic is_miss_class;
  logic is_trap;
  logic [XLEN-1:0] rewound_pc;

  always_comb begin
    is_exc        = (kind == EV_EXC);
    is_rst_class  = is_exc && (|rst_hit);
    is_miss_class = is_exc && (|miss_hit);
    is_trap       = is_exc && (eff_code == TRAP_CODE);

    rewound_pc = in_delay_slot ? (pc_in - INSN_STEP) : pc_in;
    saved_pc   = is_trap ? (rewound_pc + INSN_STEP) : rewound_pc;

    new_sr = sr_in;
    new_sr[SR_BLOCK_BIT] = 1'b1;
    new_sr[SR_BANK_BIT]  = 1'b1;
    new_sr[SR_PRIV_BIT]  = 1'b1;
    if (is_rst_class) begin
      new_sr[SR_FPUOFF_BIT] = 1'b0;
      new_sr[SR_MASK_LSB +: LVL_W] = '1;
    end

    if (kind == EV_IRQ) begin
      new_pc = vbr_in + OFS_IRQ;
    end else if (is_rst_class) begin
      new_pc = RESET_PC;
    end else if (is_miss_class) begin
      new_pc = vbr_in + OFS_MISS;
    end else begin
      new_pc = vbr_in + OFS_GEN;
    end
  end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic              in_delay_slot,
  input  logic              in_sleep,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_valid,
  input  logic [CODE_W-1:0] irq_vector,
  input  logic [LVL_W-1:0]  irq_level,
  output logic              take_event,
  output logic              expevt_ld,
  output logic              intevt_ld,
  output logic [XLEN-1:0]   ssr_q,
  output logic [XLEN-1:0]   spc_q,
  output logic [XLEN-1:0]   sgr_q,
  output logic [XLEN-1:0]   sr_q,
  output logic [XLEN-1:0]   pc_q,
  output logic [CODE_W-1:0] expevt_q,
  output logic [CODE_W-1:0] intevt_q
);

  ev_kind_e          kind;
  logic [CODE_W-1:0] eff_code;
  logic [XLEN-1:0]   new_sr;
  logic [XLEN-1:0]   new_pc;
  logic [XLEN-1:0]   saved_pc;

  trap_arbiter #(
    .CODE_W (CODE_W),
    .LVL_W  (LVL_W)
  ) u_arb (
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .irq_valid (irq_valid),
    .irq_level (irq_level),
    .sr_mask   (sr_in[SR_MASK_LSB +: LVL_W]),
    .sr_block  (sr_in[SR_BLOCK_BIT]),
    .sleeping  (in_sleep),
    .kind      (kind),
    .eff_code  (eff_code)
  );

  trap_target #(
    .XLEN   (XLEN),
    .CODE_W (CODE_W),
    .LVL_W  (LVL_W)
  ) u_tgt (
    .kind          (kind),
    .eff_code      (eff_code),
    .sr_in         (sr_in),
    .pc_in         (pc_in),
    .vbr_in        (vbr_in),
    .in_delay_slot (in_delay_slot),
    .new_sr        (new_sr),
    .new_pc        (new_pc),
    .saved_pc      (saved_pc)
  );

  // next-state
  logic take_d;
  logic exc_d;
  logic irq_d;

  always_comb begin
    exc_d  = (kind == EV_EXC);
    irq_d  = (kind == EV_IRQ);
    take_d = exc_d || irq_d;
  end

  // strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_event <= 1'b0;
      expevt_ld  <= 1'b0;
      intevt_ld  <= 1'b0;
    end else begin
      take_event <= take_d;
      expevt_ld  <= exc_d;
      intevt_ld  <= irq_d;
    end
  end

  // context registers, enabled by the entry decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssr_q <= '0;
      spc_q <= '0;
      sgr_q <= '0;
      sr_q  <= '0;
      pc_q  <= '0;
    end else if (take_d) begin
      ssr_q <= sr_in;
      spc_q <= saved_pc;
      sgr_q <= r15_in;
      sr_q  <= new_sr;
      pc_q  <= new_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expevt_q <= '0;
    end else if (exc_d) begin
      expevt_q <= eff_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intevt_q <= '0;
    end else if (irq_d) begin
      intevt_q <= irq_vector;
    end
  end

endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk
  import trap_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   sr_in,
  input logic [XLEN-1:0]   pc_in,
  input logic [XLEN-1:0]   r15_in,
  input logic [XLEN-1:0]   vbr_in,
  input logic              in_delay_slot,
  input logic              in_sleep,
  input logic              exc_valid,
  input logic [CODE_W-1:0] exc_code,
  input logic              irq_valid,
  input logic [CODE_W-1:0] irq_vector,
  input logic [LVL_W-1:0]  irq_level,
  input logic              take_event,
  input logic              expevt_ld,
  input logic              intevt_ld,
  input logic [XLEN-1:0]   ssr_q,
  input logic [XLEN-1:0]   spc_q,
  input logic [XLEN-1:0]   sgr_q,
  input logic [XLEN-1:0]   sr_q,
  input logic [XLEN-1:0]   pc_q,
  input logic [CODE_W-1:0] expevt_q,
  input logic [CODE_W-1:0] intevt_q
);

  // R1
  exc_beats_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (expevt_ld && !intevt_ld));

  // R2
  blocked_to_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && sr_in[SR_BLOCK_BIT] && exc_code != 12'h1E0)
      |=> (expevt_q == '0 && pc_q == 32'hA000_0000));

  // R3
  blocked_irq_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && sr_in[SR_BLOCK_BIT] && !in_sleep) |=> !take_event);

  // R4
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && irq_level <= sr_in[SR_MASK_LSB +: LVL_W]) |=> !take_event);

  // R5
  context_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_event |-> (ssr_q == $past(sr_in) && sgr_q == $past(r15_in)
                    && sr_q[SR_BLOCK_BIT] && sr_q[SR_BANK_BIT] && sr_q[SR_PRIV_BIT]));

  // R7
  reset_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_code == 12'h140)
      |=> (pc_q == 32'hA000_0000 && sr_q[SR_MASK_LSB +: LVL_W] == '1 && !sr_q[SR_FPUOFF_BIT]));

  // R9
  single_event_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({expevt_ld, intevt_ld}));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && !irq_valid) |=> (!take_event && $stable(pc_q) && $stable(sr_q)
                                    && $stable(spc_q)));

endmodule

bind trap_entry_seq trap_entry_seq_chk #(
  .XLEN   (XLEN),
  .CODE_W (CODE_W),
  .LVL_W  (LVL_W)
) u_chk (.*);

// File: tb/trap_entry_seq_bench.sv
`timescale 1ns/1ps
module trap_entry_seq_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] sr_in, pc_in, r15_in, vbr_in;
  logic        in_delay_slot, in_sleep;
  logic        exc_valid, irq_valid;
  logic [11:0] exc_code, irq_vector;
  logic [3:0]  irq_level;
  logic        take_event, expevt_ld, intevt_ld;
  logic [31:0] ssr_q, spc_q, sgr_q, sr_q, pc_q;
  logic [11:0] expevt_q, intevt_q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // expected state
  logic        e_take, e_exc, e_irq;
  logic [31:0] e_ssr, e_spc, e_sgr, e_sr, e_pc;
  logic [11:0] e_expevt, e_intevt;

  trap_entry_seq u_trap_entry_seq (
    .clk, .rst_n, .sr_in, .pc_in, .r15_in, .vbr_in, .in_delay_slot, .in_sleep,
    .exc_valid, .exc_code, .irq_valid, .irq_vector, .irq_level,
    .take_event, .expevt_ld, .intevt_ld, .ssr_q, .spc_q, .sgr_q, .sr_q, .pc_q,
    .expevt_q, .intevt_q
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_rst_code(input logic [11:0] c);
    return (c == 12'h000) || (c == 12'h020) || (c == 12'h140);
  endfunction

  task automatic predict();
    logic        blk;
    logic [11:0] code;
    logic [31:0] spc;
    blk   = sr_in[28];
    code  = (blk && exc_code != 12'h1E0) ? 12'h000 : exc_code;
    e_exc = exc_valid;
    e_irq = !exc_valid && irq_valid && (!blk || in_sleep) && (irq_level > sr_in[7:4]);
    e_take = e_exc || e_irq;
    if (e_take) begin
      spc = in_delay_slot ? pc_in - 32'd2 : pc_in;
      if (e_exc && code == 12'h160) spc = spc + 32'd2;
      e_ssr = sr_in;
      e_sgr = r15_in;
      e_spc = spc;
      e_sr  = sr_in | 32'h7000_0000;
      if (e_exc && is_rst_code(code)) begin
        e_sr[15]  = 1'b0;
        e_sr[7:4] = 4'hF;
        e_pc = 32'hA000_0000;
      end else if (e_irq) begin
        e_pc = vbr_in + 32'h600;
      end else if (code == 12'h040 || code == 12'h060) begin
        e_pc = vbr_in + 32'h400;
      end else begin
        e_pc = vbr_in + 32'h100;
      end
      if (e_exc) e_expevt = code;
      if (e_irq) e_intevt = irq_vector;
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "take_event", {31'd0, take_event}, {31'd0, e_take});
    chk(tag, "expevt_ld",  {31'd0, expevt_ld},  {31'd0, e_exc});
    chk(tag, "intevt_ld",  {31'd0, intevt_ld},  {31'd0, e_irq});
    chk(tag, "ssr", ssr_q, e_ssr);
    chk(tag, "spc", spc_q, e_spc);
    chk(tag, "sgr", sgr_q, e_sgr);
    chk(tag, "sr",  sr_q,  e_sr);
    chk(tag, "pc",  pc_q,  e_pc);
    chk(tag, "expevt", {20'd0, expevt_q}, {20'd0, e_expevt});
    chk(tag, "intevt", {20'd0, intevt_q}, {20'd0, e_intevt});
  endtask

  // inputs are set at a falling edge; outputs are sampled one cycle later
  task automatic step(input string tag);
    predict();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic set_req(input logic [31:0] sr, input logic ds, input logic slp,
                         input logic ev, input logic [11:0] code,
                         input logic iv, input logic [11:0] vec, input logic [3:0] lvl);
    sr_in = sr; in_delay_slot = ds; in_sleep = slp;
    exc_valid = ev; exc_code = code; irq_valid = iv; irq_vector = vec; irq_level = lvl;
    pc_in  = 32'h8C00_1000 + {16'd0, $urandom_range(0, 255), 2'b00};
    r15_in = $urandom;
    vbr_in = 32'h8C00_0000 + {20'd0, $urandom_range(0, 15), 8'd0};
  endtask

  task automatic go_idle(input string tag);
    set_req(32'h0000_00F0, 1'b0, 1'b0, 1'b0, 12'h0, 1'b0, 12'h0, 4'h0);
    step(tag);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd7321);
    rst_n = 1'b0;
    sr_in = '0; pc_in = '0; r15_in = '0; vbr_in = '0;
    in_delay_slot = 1'b0; in_sleep = 1'b0;
    exc_valid = 1'b0; exc_code = '0; irq_valid = 1'b0; irq_vector = '0; irq_level = '0;
    e_ssr = '0; e_spc = '0; e_sgr = '0; e_sr = '0; e_pc = '0; e_expevt = '0; e_intevt = '0;
    e_take = 1'b0; e_exc = 1'b0; e_irq = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    compare_all("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 exception and interrupt together
    set_req(32'h0000_0000, 1'b0, 1'b0, 1'b1, 12'h180, 1'b1, 12'h3C0, 4'hF);
    step("R1 exc beats irq");
    go_idle("R10 idle after R1");

    // R2 blocked exception becomes reset, 0x1E0 passes
    set_req(32'h1000_0030, 1'b0, 1'b0, 1'b1, 12'h0A0, 1'b0, 12'h0, 4'h0);
    step("R2 blocked to reset");
    set_req(32'h1000_0030, 1'b0, 1'b0, 1'b1, 12'h1E0, 1'b0, 12'h0, 4'h0);
    step("R2 unblockable code");

    // R3 blocked interrupt ignored unless sleeping
    set_req(32'h1000_0000, 1'b0, 1'b0, 1'b0, 12'h0, 1'b1, 12'h320, 4'hA);
    step("R3 blocked irq ignored");
    set_req(32'h1000_0000, 1'b0, 1'b1, 1'b0, 12'h0, 1'b1, 12'h320, 4'hA);
    step("R3 sleeping irq taken");

    // R4 level edge
    set_req(32'h0000_0070, 1'b0, 1'b0, 1'b0, 12'h0, 1'b1, 12'h200, 4'h7);
    step("R4 level equal mask");
    set_req(32'h0000_0070, 1'b0, 1'b0, 1'b0, 12'h0, 1'b1, 12'h220, 4'h8);
    step("R4 level above mask");

    // R5 / R6 context save with delay slot
    set_req(32'h0000_8010, 1'b1, 1'b0, 1'b1, 12'h180, 1'b0, 12'h0, 4'h0);
    step("R5 R6 delay slot save");

    // R7 reset-class codes
    set_req(32'h0000_8000, 1'b0, 1'b0, 1'b1, 12'h020, 1'b0, 12'h0, 4'h0);
    step("R7 code 020");
    set_req(32'h0000_8050, 1'b0, 1'b0, 1'b1, 12'h140, 1'b0, 12'h0, 4'h0);
    step("R7 code 140");

    // R8 vector classes and trap adjustment
    set_req(32'h0000_0000, 1'b0, 1'b0, 1'b1, 12'h040, 1'b0, 12'h0, 4'h0);
    step("R8 miss 040");
    set_req(32'h0000_0000, 1'b0, 1'b0, 1'b1, 12'h060, 1'b0, 12'h0, 4'h0);
    step("R8 miss 060");
    set_req(32'h0000_0000, 1'b0, 1'b0, 1'b1, 12'h160, 1'b0, 12'h0, 4'h0);
    step("R8 trap");
    set_req(32'h0000_0000, 1'b1, 1'b0, 1'b1, 12'h160, 1'b0, 12'h0, 4'h0);
    step("R8 trap in delay slot");

    // R9 interrupt keeps mask and FPU bit
    set_req(32'h0000_8020, 1'b0, 1'b0, 1'b0, 12'h0, 1'b1, 12'h5A0, 4'h9);
    step("R9 irq entry");
    go_idle("R10 hold");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [11:0] codes [8];
      logic [31:0] sr;
      codes = '{12'h000, 12'h020, 12'h040, 12'h060, 12'h140, 12'h160, 12'h1E0,
                12'({$urandom_range(0, 127), 5'd0})};
      sr = $urandom & 32'h1000_80F0;
      set_req(sr, 1'($urandom), 1'($urandom_range(0, 3) == 0),
              1'($urandom_range(0, 2) == 0), codes[$urandom_range(0, 7)],
              1'($urandom), 12'({$urandom_range(0, 127), 5'd0}), 4'($urandom));
      step("R9 random model");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule